// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds one 8-bit priority field for each of up to 240 interrupt lines. Software reaches the fields through a plain word-addressed register bus with byte strobes. Four fields share each 32-bit word, so a byte-wide store updates exactly one interrupt's priority. Only the upper bits of every field exist in storage. The lower bits always read back as zero, and data written to them is dropped.

The bank also watches three per-line vectors from the interrupt fabric: pending, enable and active. The active vector can be read back over the same bus as a set of status words. Every cycle the bank looks at all lines that are both pending and enabled. It registers the number and priority of the most urgent one, where a smaller priority value is more urgent. When two or more candidates hold the same priority, the lowest interrupt number is chosen.

Top module: `ipr_bank`

## Requirements
- R1: Word addresses 0 to 59 each hold four priority fields, 240 in total; the field of interrupt m lives in word m/4 (integer division).
- R2: Inside a priority word, interrupt m sits in byte lane m%4, with lane 0 at bits [7:0], lane 1 at [15:8], lane 2 at [23:16] and lane 3 at [31:24].
- R3: A write changes only those fields whose byte strobe bit (bit k selects lane k) is 1; other lanes keep their value.
- R4: Only field bits [7:LSB_CUT] are stored (default LSB_CUT=4); bits [LSB_CUT-1:0] read as 0 on the bus and on win_prio, whatever was written.
- R5: Among lines with irq_pending and irq_enable both 1, the selected line has the numerically smallest stored priority.
- R6: When candidates tie on priority, the smallest interrupt number is selected.
- R7: win_valid is 1 only when at least one line is pending and enabled; when it is 0, win_id and win_prio are 0.
- R8: win_valid, win_id and win_prio are registered: they show the inputs and stored priorities of the previous clock edge and do not change between edges.
- R9: After reset every priority field is 0 and win_valid is 0.
- R10: A read of any word address that is neither a priority word (0..59) nor a status word (64..71) returns 0, and reads change no stored state.
- R11: Status word 64+k, bit b reads irq_active[32k+b], 1 whenever that line is active, whether or not it is also pending; bits at or above line 240 read 0.
- R12: A read sampled on bus_rd at an edge shows its data on bus_rdata after that edge, and bus_rdata holds its value while bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 7 | Word address |
| bus_wstrb | input | 4 | Byte lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pending | input | 240 | Pending flag per line |
| irq_enable | input | 240 | Enable flag per line |
| irq_active | input | 240 | Active flag per line |
| win_valid | output | 1 | A pending, enabled line exists |
| win_id | output | 8 | Number of the most urgent candidate |
| win_prio | output | 8 | Priority of that candidate |

## Verification
A stored field that is corrupted shows up in two places. The next read of its word returns the wrong value. Once that line is pending and enabled, the winner can also differ from a linear scan of the intended priorities. Both effects appear one clock after the cause. A lane decode that is off by one, or a strobe that leaks into another lane, shows up as a mismatch in the neighbouring byte on the very next read-back. A wrong tie rule or a wrong comparison direction gives a wrong win_id as soon as two candidates share a priority, or as soon as they differ in priority.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
    localparam int ID_W   = 8;
    localparam int FLD_W  = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / FLD_W;

    typedef struct packed {
        logic             vld;
        logic [ID_W-1:0]  id;
        logic [FLD_W-1:0] prio;
    } cand_t;
endpackage

// File: rtl/ipr_field_store.sv
module ipr_field_store
    import ipr_pkg::*;
#(
    parameter int NUM_IRQ = 240,
    parameter int LSB_CUT = 4,
    parameter int ADDR_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         wstrb,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NUM_IRQ*FLD_W-1:0] prio_flat
);
    localparam int SB    = FLD_W - LSB_CUT;
    localparam int WORDS = (NUM_IRQ + LANES - 1) / LANES;

    typedef logic [SB-1:0] fld_t;

    fld_t fld_d [NUM_IRQ];
    fld_t fld_q [NUM_IRQ];

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            fld_d[i] = fld_q[i];
        end
        if (wr_en && (int'(addr) < WORDS)) begin
            for (int l = 0; l < LANES; l++) begin
                if (wstrb[l] && (int'(addr) * LANES + l < NUM_IRQ)) begin
                    fld_d[int'(addr) * LANES + l] = wdata[l*FLD_W + LSB_CUT +: SB];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                fld_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                fld_q[i] <= fld_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_expand
        assign prio_flat[g*FLD_W +: FLD_W] = FLD_W'(fld_q[g]) << LSB_CUT;
    end
endmodule

// File: rtl/ipr_urgent_pick.sv
module ipr_urgent_pick
    import ipr_pkg::*;
#(
    parameter int NUM_IRQ = 240
) (
    input  logic [NUM_IRQ*FLD_W-1:0] prio_flat,
    input  logic [NUM_IRQ-1:0]       cand,
    output cand_t                    best
);
    localparam int LVLS = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int P    = 1 << LVLS;
    localparam int NODES = 2 * P - 1;

    cand_t node [NODES];

    for (genvar k = 0; k < P; k++) begin : g_leaf
        if (k < NUM_IRQ) begin : g_real
            assign node[P-1+k] = '{vld: cand[k], id: ID_W'(k),
                                   prio: prio_flat[k*FLD_W +: FLD_W]};
        end else begin : g_pad
            assign node[P-1+k] = '0;
        end
    end

    // Left subtree always covers lower interrupt numbers, so it wins ties.
    for (genvar n = 0; n < P - 1; n++) begin : g_node
        assign node[n] = (node[2*n+1].vld &&
                          (!node[2*n+2].vld || node[2*n+1].prio <= node[2*n+2].prio))
                         ? node[2*n+1] : node[2*n+2];
    end

    assign best = node[0];
endmodule

// File: rtl/ipr_bank.sv
module ipr_bank
    import ipr_pkg::*;
#(
    parameter int NUM_IRQ  = 240,
    parameter int LSB_CUT  = 4,
    parameter int ADDR_W   = 7,
    parameter int ACT_BASE = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [LANES-1:0]    bus_wstrb,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_IRQ-1:0]  irq_pending,
    input  logic [NUM_IRQ-1:0]  irq_enable,
    input  logic [NUM_IRQ-1:0]  irq_active,
    output logic                win_valid,
    output logic [ID_W-1:0]     win_id,
    output logic [FLD_W-1:0]    win_prio
);
    localparam int WORDS     = (NUM_IRQ + LANES - 1) / LANES;
    localparam int ACT_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        cand_t             win;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_IRQ*FLD_W-1:0] prio_flat;
    cand_t                    best;

    ipr_field_store #(
        .NUM_IRQ (NUM_IRQ),
        .LSB_CUT (LSB_CUT),
        .ADDR_W  (ADDR_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wstrb     (bus_wstrb),
        .wdata     (bus_wdata),
        .prio_flat (prio_flat)
    );

    ipr_urgent_pick #(
        .NUM_IRQ (NUM_IRQ)
    ) pick_i (
        .prio_flat (prio_flat),
        .cand      (irq_pending & irq_enable),
        .best      (best)
    );

    logic [WORD_W-1:0] rd_word;

    always_comb begin
        int a;
        a = int'(bus_addr);
        rd_word = '0;
        if (a < WORDS) begin
            for (int b = 0; b < WORD_W; b++) begin
                if (a * WORD_W + b < NUM_IRQ * FLD_W) begin
                    rd_word[b] = prio_flat[a * WORD_W + b];
                end
            end
        end else if (a >= ACT_BASE && a < ACT_BASE + ACT_WORDS) begin
            for (int b = 0; b < WORD_W; b++) begin
                if ((a - ACT_BASE) * WORD_W + b < NUM_IRQ) begin
                    rd_word[b] = irq_active[(a - ACT_BASE) * WORD_W + b];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_word;
        end
        st_d.win = best.vld ? best : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign win_valid = st_q.win.vld;
    assign win_id    = st_q.win.id;
    assign win_prio  = st_q.win.prio;
endmodule

// File: rtl/ipr_bank_chk.sv
module ipr_bank_chk
    import ipr_pkg::*;
#(
    parameter int NUM_IRQ  = 240,
    parameter int LSB_CUT  = 4,
    parameter int ADDR_W   = 7,
    parameter int ACT_BASE = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic [NUM_IRQ-1:0]  irq_pending,
    input logic [NUM_IRQ-1:0]  irq_enable,
    input logic                win_valid,
    input logic [ID_W-1:0]     win_id,
    input logic [FLD_W-1:0]    win_prio
);
    localparam int WORDS     = (NUM_IRQ + LANES - 1) / LANES;
    localparam int ACT_WORDS = (NUM_IRQ + WORD_W - 1) / WORD_W;
    localparam logic [FLD_W-1:0]  LOW_MASK  = FLD_W'((1 << LSB_CUT) - 1);
    localparam logic [WORD_W-1:0] WORD_MASK = {LANES{LOW_MASK}};

    logic               past_ok;
    logic [NUM_IRQ-1:0] cand_q;
    logic               unm_q;
    logic               prd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            cand_q  <= '0;
            unm_q   <= 1'b0;
            prd_q   <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            cand_q  <= irq_pending & irq_enable;
            unm_q   <= bus_rd && (int'(bus_addr) >= WORDS) &&
                       !(int'(bus_addr) >= ACT_BASE && int'(bus_addr) < ACT_BASE + ACT_WORDS);
            prd_q   <= bus_rd && (int'(bus_addr) < WORDS);
        end
    end

    AST_WIN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio & LOW_MASK) == '0); // R4

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prd_q |-> (bus_rdata & WORD_MASK) == '0); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_id == '0 && win_prio == '0)); // R7

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (win_valid == (|cand_q))); // R7

    AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && win_valid) |-> (int'(win_id) < NUM_IRQ && cand_q[win_id])); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unm_q |-> bus_rdata == '0); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(bus_rd)) |-> $stable(bus_rdata)); // R12
endmodule

bind ipr_bank ipr_bank_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .LSB_CUT  (LSB_CUT),
    .ADDR_W   (ADDR_W),
    .ACT_BASE (ACT_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .win_valid   (win_valid),
    .win_id      (win_id),
    .win_prio    (win_prio)
);

// File: tb/ipr_bank_tb_top.sv
`timescale 1ns/1ps
module ipr_bank_tb_top;
    localparam int NUM = 240;
    localparam int CUT = 4;
    localparam logic [7:0] HI_MASK = 8'hFF << CUT;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic [3:0]   bus_wstrb = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [NUM-1:0] irq_pending = '0;
    logic [NUM-1:0] irq_enable = '0;
    logic [NUM-1:0] irq_active = '0;
    logic         win_valid;
    logic [7:0]   win_id;
    logic [7:0]   win_prio;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_p [NUM];

    always #2.5 clk = ~clk;

    ipr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pending(irq_pending), .irq_enable(irq_enable),
        .irq_active(irq_active), .win_valid(win_valid), .win_id(win_id),
        .win_prio(win_prio)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'(a); bus_wstrb = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
        for (int l = 0; l < 4; l++) begin
            if (s[l] && a < 60) ref_p[a*4+l] = d[l*8 +: 8] & HI_MASK;
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 7'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_word(input int a);
        logic [31:0] w;
        w = '0;
        for (int l = 0; l < 4; l++) w[l*8 +: 8] = ref_p[a*4+l];
        return w;
    endfunction

    function automatic logic [NUM-1:0] rnd_vec();
        logic [NUM-1:0] v;
        for (int i = 0; i < NUM; i++) v[i] = 1'($urandom);
        return v;
    endfunction

    task automatic win_check(input string tag);
        int best;
        logic [7:0] op, oi;
        logic ov;
        ov = win_valid; oi = win_id; op = win_prio;
        best = -1;
        for (int i = 0; i < NUM; i++) begin
            if (irq_pending[i] && irq_enable[i] && (best < 0 || ref_p[i] < ref_p[best])) best = i;
        end
        #1;
        chk(win_valid == ov && win_id == oi && win_prio == op, "R8 outputs held before edge",
            {win_valid, win_id, win_prio}, {ov, oi, op});
        @(negedge clk);
        if (best < 0)
            chk(!win_valid && win_id == 0 && win_prio == 0, {tag, " R7 idle"},
                {win_valid, win_id, win_prio}, 0);
        else
            chk(win_valid && win_id == 8'(best) && win_prio == ref_p[best], {tag, " R5 R6 winner"},
                {win_valid, win_id, win_prio}, {1'b1, 8'(best), ref_p[best]});
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NUM; i++) ref_p[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!win_valid && win_id == 0 && win_prio == 0, "R9 winner after reset",
            {win_valid, win_id, win_prio}, 0);
        for (int a = 0; a < 60; a++) begin
            rd(a, d);
            chk(d == 0, "R9 field reset", d, 0);
        end

        // R1 R2 R3 R4: every word under all strobe patterns
        for (int a = 0; a < 60; a++) begin
            for (int s = 0; s < 16; s++) begin
                wr(a, 4'(s), $urandom);
                rd(a, d);
                chk(d == exp_word(a), "R1 R2 R3 R4 readback", d, exp_word(a));
            end
        end
        // R2: one-hot lane placement for interrupt m
        for (int m = 0; m < NUM; m += 7) begin
            wr(m/4, 4'b1 << (m%4), 32'hFFFF_FFFF);
            rd(m/4, d);
            chk(d[(m%4)*8 +: 8] == HI_MASK, "R2 lane position", d, exp_word(m/4));
        end

        // R11 status words, R10 unmapped reads
        irq_active = rnd_vec();
        irq_pending = rnd_vec();
        for (int k = 0; k < 8; k++) begin
            logic [31:0] e;
            e = '0;
            for (int b = 0; b < 32; b++) if (k*32+b < NUM) e[b] = irq_active[k*32+b];
            rd(64 + k, d);
            chk(d == e, "R11 active status", d, e);
        end
        for (int a = 60; a < 128; a++) begin
            if (a < 64 || a >= 72) begin
                rd(a, d);
                chk(d == 0, "R10 unmapped read", d, 0);
            end
        end
        for (int a = 0; a < 60; a++) begin
            rd(a, d);
            chk(d == exp_word(a), "R10 no side effect", d, exp_word(a));
        end
        // R12 hold while idle
        rd(5, d);
        @(negedge clk); bus_addr = 7'd9;
        @(negedge clk);
        chk(bus_rdata == exp_word(5), "R12 rdata held", bus_rdata, exp_word(5));

        // R5 R6 R7 R8 winner selection
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            irq_pending = rnd_vec();
            irq_enable = (t % 3 == 0) ? rnd_vec() & rnd_vec() & rnd_vec() : rnd_vec();
            if (t % 50 == 7) irq_enable = '0;
            win_check("random");
        end
        // R6: all equal priorities, everything pending
        for (int a = 0; a < 60; a++) wr(a, 4'hF, 32'h5555_5555);
        @(negedge clk);
        irq_pending = '1; irq_enable = '1;
        win_check("R6 all tie");
        chk(win_id == 0, "R6 tie lowest id", win_id, 0);
        @(negedge clk);
        irq_enable[0] = 1'b0; irq_enable[1] = 1'b0;
        win_check("R6 tie skip disabled");
        wr(59, 4'b1000, 32'h0000_0000);
        @(negedge clk);
        win_check("R5 last line most urgent");
        @(negedge clk);
        irq_pending = '0;
        win_check("R7 none pending");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule